// File: doc/BRIEF.md
# Retrospective Segment-Sequence Checker

This block confirms that the segments of a long pattern arrive in the right order and with the right spacing. An upstream matcher reports one segment index per cycle. Each index addresses one entry of a 1024-word table. That entry names the segment that must have come before, how many cycles earlier it must have come, and what role the segment plays in its pattern.

The checker keeps a short history of recent indices, together with a flag saying whether each one continued a valid chain. For every arriving segment it looks back by the stored gap. If the history slot at that gap is marked valid and holds the expected predecessor, the chain continues. A segment typed as the start of a pattern always begins a chain. When a segment typed as the end of a pattern completes a valid chain, the block reports that index as a long-pattern hit.

Segments typed as short patterns are reported with the same latency as long-pattern hits, on the same output. Software loads the table through a simple write port.

Top module: `seq_chain_checker`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `hit_valid` and `hit_idx` are 0. Reset also empties the history, so a chain never completes through a segment seen before the reset.
- R2: When `wr_en` is high at a rising edge, `wr_data` is stored at table address `wr_addr`. The entry layout is: bits [9:0] predecessor index; bits [12:10] gap code (code c means c+1 cycles back); bits [14:13] type (0 start, 1 middle, 2 end, 3 short); bit [15] entry valid; bits [17:16] reserved.
- R3: A segment sampled on `seg_valid`/`seg_idx` at rising edge k produces its result on `hit_valid`/`hit_idx` right after edge k+1. Segments on consecutive cycles give results on consecutive cycles.
- R4: A valid entry of type short gives a one-cycle hit carrying that segment's own index.
- R5: A valid entry of type start begins a chain regardless of the history, and gives no hit on its own.
- R6: A middle or end segment continues a chain only if the history slot at its gap is chain-valid and holds its stored predecessor index.
- R7: An end segment whose chain check passes gives a one-cycle hit carrying the end segment's index.
- R8: A predecessor at the wrong gap, a wrong predecessor, or a broken earlier link gives no hit.
- R9: A segment whose entry-valid bit is 0 gives no hit and does not continue any chain.
- R10: The reserved bits [17:16] have no effect on behaviour.
- R11: The largest gap code, 7, reaches a predecessor exactly 8 cycles earlier, and no other.
- R12: `hit_idx` is 0 whenever `hit_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 10 | Table write address |
| wr_data | input | 18 | Table entry to store |
| seg_valid | input | 1 | A segment index is presented this cycle |
| seg_idx | input | 10 | Detected segment index |
| hit_valid | output | 1 | A short or long pattern was found |
| hit_idx | output | 10 | Index of the found pattern, 0 when idle |

## Verification
A segment sampled at one rising edge first takes a registered table read. Its result is registered at the next edge, so every hit, whether short or long, is due two edges after its segment. A table write is visible to a segment sampled at the following edge.

The bench drives inputs on the falling edge. Before driving each new row, it compares the outputs against the response expected to the segment driven two falling edges earlier. Gap checks therefore count whole cycles between the falling edges at which the segments were driven.

// File: rtl/seq_chain_checker.sv
module seq_chain_checker #(
  parameter int IDX_W = 10,
  parameter int GAP_W = 3,
  parameter int RSV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [IDX_W+GAP_W+3+RSV_W-1:0] wr_data,
  input  logic             seg_valid,
  input  logic [IDX_W-1:0] seg_idx,
  output logic             hit_valid,
  output logic [IDX_W-1:0] hit_idx
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int HIST  = 1 << GAP_W;
  localparam int ENT_W = IDX_W + GAP_W + 3 + RSV_W;
  localparam logic [1:0] T_START = 2'd0, T_MID = 2'd1, T_END = 2'd2, T_SHORT = 2'd3;

  logic [ENT_W-1:0] tbl [DEPTH];
  logic [ENT_W-1:0] ent;
  logic             s1_v;
  logic [IDX_W-1:0] s1_idx;
  logic [IDX_W-1:0] h_idx [HIST];
  logic [HIST-1:0]  h_ok;
  logic [1:0]       age;

  always_ff @(posedge clk) begin
    if (wr_en) tbl[wr_addr] <= wr_data;
    ent <= tbl[seg_idx];
  end

  wire [IDX_W-1:0] e_prev = ent[IDX_W-1:0];
  wire [GAP_W-1:0] e_gap  = ent[IDX_W +: GAP_W];
  wire [1:0]       e_typ  = ent[IDX_W+GAP_W +: 2];
  wire             e_vld  = ent[IDX_W+GAP_W+2];
  wire             unused_rsv = ^ent[ENT_W-1 -: RSV_W];

  wire live      = s1_v & e_vld;
  wire link_ok   = h_ok[e_gap] & (h_idx[e_gap] == e_prev);
  wire cur_ok    = live & ((e_typ == T_START) | ((e_typ == T_MID | e_typ == T_END) & link_ok));
  wire long_hit  = live & (e_typ == T_END) & link_ok;
  wire short_hit = live & (e_typ == T_SHORT);
  wire [IDX_W-1:0] hit_next = ({IDX_W{long_hit}} & s1_idx) | ({IDX_W{short_hit}} & s1_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s1_idx    <= '0;
      h_ok      <= '0;
      for (int k = 0; k < HIST; k++) h_idx[k] <= '0;
      hit_valid <= 1'b0;
      hit_idx   <= '0;
      age       <= '0;
    end else begin
      s1_v      <= seg_valid;
      s1_idx    <= seg_idx;
      h_ok      <= {h_ok[HIST-2:0], cur_ok};
      h_idx[0]  <= s1_idx;
      for (int k = 1; k < HIST; k++) h_idx[k] <= h_idx[k-1];
      hit_valid <= long_hit | short_hit;
      hit_idx   <= hit_next;
      if (age != 2'd2) age <= age + 2'd1;
    end
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!hit_valid && hit_idx == '0));

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tbl[$past(wr_addr)] == $past(wr_data));

  assert_hit_has_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && age == 2'd2) |-> $past(seg_valid, 2));

  assert_hit_needs_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> $past(e_vld));

  assert_idle_index_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_valid |-> hit_idx == '0);
endmodule

// File: tb/seq_chain_checker_tb.sv
module seq_chain_checker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [9:0] wr_addr = '0;
  logic [17:0] wr_data = '0;
  logic seg_valid = 1'b0;
  logic [9:0] seg_idx = '0;
  logic hit_valid;
  logic [9:0] hit_idx;
  int total = 0;
  int bad = 0;
  bit done = 0;

  seq_chain_checker u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .seg_valid(seg_valid), .seg_idx(seg_idx), .hit_valid(hit_valid), .hit_idx(hit_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // row: {seg_valid, seg_idx, expected hit_valid, expected hit_idx};
  // expected fields are the response to the previous row's input
  localparam logic [21:0] VEC [NV] = '{
    {1'b0,10'd0, 1'b0,10'd0},  {1'b1,10'd5, 1'b0,10'd0},  {1'b0,10'd0, 1'b1,10'd5},
    {1'b1,10'd10,1'b0,10'd0},  {1'b0,10'd0, 1'b0,10'd0},  {1'b0,10'd0, 1'b0,10'd0},
    {1'b1,10'd11,1'b0,10'd0},  {1'b1,10'd12,1'b0,10'd0},  {1'b0,10'd0, 1'b1,10'd12},
    {1'b1,10'd10,1'b0,10'd0},  {1'b0,10'd0, 1'b0,10'd0},  {1'b1,10'd11,1'b0,10'd0},
    {1'b1,10'd12,1'b0,10'd0},  {1'b0,10'd0, 1'b0,10'd0},  {1'b1,10'd12,1'b0,10'd0},
    {1'b0,10'd0, 1'b0,10'd0},  {1'b1,10'd10,1'b0,10'd0},  {1'b1,10'd31,1'b0,10'd0},
    {1'b0,10'd0, 1'b0,10'd0},  {1'b1,10'd10,1'b0,10'd0},  {1'b1,10'd40,1'b0,10'd0},
    {1'b0,10'd0, 1'b1,10'd40}, {1'b1,10'd20,1'b0,10'd0},  {1'b0,10'd0, 1'b0,10'd0},
    {1'b0,10'd0, 1'b0,10'd0},  {1'b0,10'd0, 1'b0,10'd0},  {1'b0,10'd0, 1'b0,10'd0},
    {1'b0,10'd0, 1'b0,10'd0},  {1'b0,10'd0, 1'b0,10'd0},  {1'b0,10'd0, 1'b0,10'd0},
    {1'b1,10'd21,1'b0,10'd0},  {1'b0,10'd0, 1'b1,10'd21}, {1'b1,10'd20,1'b0,10'd0},
    {1'b0,10'd0, 1'b0,10'd0},  {1'b0,10'd0, 1'b0,10'd0},  {1'b0,10'd0, 1'b0,10'd0},
    {1'b0,10'd0, 1'b0,10'd0},  {1'b0,10'd0, 1'b0,10'd0},  {1'b0,10'd0, 1'b0,10'd0},
    {1'b1,10'd21,1'b0,10'd0},  {1'b0,10'd0, 1'b0,10'd0},  {1'b1,10'd13,1'b0,10'd0},
    {1'b0,10'd0, 1'b0,10'd0},  {1'b0,10'd0, 1'b0,10'd0},  {1'b1,10'd11,1'b0,10'd0},
    {1'b1,10'd12,1'b0,10'd0},  {1'b0,10'd0, 1'b0,10'd0},  {1'b1,10'd5, 1'b0,10'd0},
    {1'b1,10'd5, 1'b1,10'd5},  {1'b0,10'd0, 1'b1,10'd5},  {1'b0,10'd0, 1'b0,10'd0},
    {1'b0,10'd0, 1'b0,10'd0}
  };

  function automatic logic [17:0] mk(input logic [1:0] rsv, input logic v, input logic [1:0] typ,
                                     input logic [2:0] gap, input logic [9:0] prev);
    return {rsv, v, typ, gap, prev};
  endfunction

  function automatic string row_tag(input int r);
    if (r <= 2) return "R4";
    if (r <= 5) return "R5";
    if (r <= 8) return "R7";
    if (r <= 15) return "R8";
    if (r <= 18) return "R9";
    if (r <= 21) return "R10";
    if (r <= 31) return "R11";
    if (r <= 40) return "R8";
    if (r <= 46) return "R6";
    return "R3";
  endfunction

  task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got valid=%0b idx=%0d, expected valid=%0b idx=%0d",
               tag, act[10], act[9:0], exp[10], exp[9:0]);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [17:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive(input logic v, input logic [9:0] i);
    seg_valid = v; seg_idx = i;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {hit_valid, hit_idx}, 11'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {hit_valid, hit_idx}, 11'd0);

    for (int a = 0; a < 1024; a++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a[9:0]; wr_data = '0;
    end
    @(negedge clk);
    wr_en = 1'b0;
    wr(10'd5,  mk(2'd0, 1'b1, 2'd3, 3'd0, 10'd0));
    wr(10'd10, mk(2'd0, 1'b1, 2'd0, 3'd0, 10'd0));
    wr(10'd11, mk(2'd0, 1'b1, 2'd1, 3'd2, 10'd10));
    wr(10'd12, mk(2'd0, 1'b1, 2'd2, 3'd0, 10'd11));
    wr(10'd13, mk(2'd0, 1'b1, 2'd0, 3'd0, 10'd0));
    wr(10'd20, mk(2'd0, 1'b1, 2'd0, 3'd0, 10'd0));
    wr(10'd21, mk(2'd0, 1'b1, 2'd2, 3'd7, 10'd20));
    wr(10'd31, mk(2'd0, 1'b0, 2'd2, 3'd0, 10'd10));
    wr(10'd40, mk(2'd3, 1'b1, 2'd2, 3'd0, 10'd10));
    repeat (3) @(negedge clk);

    for (int i = 0; i <= NV; i++) begin
      if (i > 0) begin
        if (VEC[i-1][10]) chk(row_tag(i-1), {hit_valid, hit_idx}, VEC[i-1][10:0]);
        else chk({row_tag(i-1), "/R12"}, {hit_valid, hit_idx}, 11'd0);
      end
      if (i < NV) drive(VEC[i][21], VEC[i][20:11]);
      else drive(1'b0, '0);
      @(negedge clk);
    end

    // R3: a short hit is not early after one edge, then appears after two
    drive(1'b1, 10'd5);
    @(negedge clk);
    drive(1'b0, '0);
    chk("R3 early", {hit_valid, hit_idx}, 11'd0);
    @(negedge clk);
    chk("R3 due", {hit_valid, hit_idx}, {1'b1, 10'd5});
    @(negedge clk);
    chk("R3 one cycle", {hit_valid, hit_idx}, 11'd0);

    // R1: a reset between start and middle breaks the chain
    drive(1'b1, 10'd10);
    @(negedge clk);
    drive(1'b0, '0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b1, 10'd11);
    @(negedge clk);
    drive(1'b1, 10'd12);
    @(negedge clk);
    drive(1'b0, '0);
    chk("R1 history", {hit_valid, hit_idx}, 11'd0);
    @(negedge clk);
    chk("R1 history", {hit_valid, hit_idx}, 11'd0);

    // control: the same chain with no reset completes
    drive(1'b1, 10'd10);
    repeat (3) @(negedge clk) drive(1'b0, '0);
    drive(1'b1, 10'd11);
    @(negedge clk);
    drive(1'b1, 10'd12);
    @(negedge clk);
    drive(1'b0, '0);
    @(negedge clk);
    chk("R7 control", {hit_valid, hit_idx}, {1'b1, 10'd12});

    // R2: overwriting an entry as invalid stops its hits
    wr(10'd5, mk(2'd0, 1'b0, 2'd3, 3'd0, 10'd0));
    drive(1'b1, 10'd5);
    @(negedge clk);
    drive(1'b0, '0);
    @(negedge clk);
    chk("R2 overwrite", {hit_valid, hit_idx}, 11'd0);
    @(negedge clk);
    chk("R2 overwrite", {hit_valid, hit_idx}, 11'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule